// File: doc/BRIEF.md
# Fused Integer Multiply Unit

This execution unit performs the four 32-bit integer multiply operations of a RISC-style core. One operation returns the low word of the product. The other three return the high word, treating the operands as signed×signed, signed×unsigned or unsigned×unsigned. Each operation arrives already decoded, carrying its opcode, its two source register numbers, its destination register number and both operand values. It is accepted with a valid/ready handshake. After a fixed number of cycles the unit returns one write-back, consisting of a result word and its destination register.

Software that needs a full double-width product issues a high-word multiply followed by a low-word multiply on the same two registers. The unit spots this pairing while the high-word operation is still in flight. It then accepts the low-word operation at once and runs no second multiplication. The low word is read from the product register the high-word operation already filled. Both write-backs leave on consecutive cycles, high word first.

Pairing is refused when the low-word operation names its sources in the other order. It is also refused when the high-word destination overwrites one of the sources, because the second operation's operand values could then differ. A flush input drops whatever is in flight, including a low-word operation already paired with it.

Top module: `mulfuse_unit`

## Requirements
- R1: Opcode 0 (low word) returns bits [31:0] of the 64-bit product of in_a and in_b.
- R2: Opcode 1 returns bits [63:32] of the product with both operands taken as two's-complement signed.
- R3: Opcode 2 returns bits [63:32] of the product with in_a signed and in_b unsigned.
- R4: Opcode 3 returns bits [63:32] of the product with both operands unsigned.
- R5: An operation accepted at clock edge k and not paired presents out_valid, its destination on out_rd and its result for exactly one cycle, the cycle after edge k+LAT (LAT=3 by default). in_ready is low from acceptance until that write-back cycle has ended.
- R6: Suppose a high-word operation (opcodes 1 to 3) is in flight and has not yet written back, and the first operation offered after it is opcode 0 with the same rs1 and the same rs2. That operation is then accepted without waiting. Its low word, taken from the product of the high-word operation, is written back in the cycle directly after the high-word write-back.
- R7: A low-word operation whose sources are swapped relative to the preceding high-word operation is not paired. It is accepted only after the high-word write-back and takes the full latency of R5.
- R8: No pairing takes place when the high-word destination equals its rs1 or its rs2.
- R9: Only a high-word operation followed by a low-word operation pairs. A low word followed by a low word, or a high word followed by another high word, executes as two separate operations.
- R10: Asserting flush for one cycle discards the in-flight operation and any paired low-word operation. No write-back appears in the flush cycle or later for either, and in_ready is high in the next cycle.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard in-flight and paired work |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The offered operation is accepted this cycle |
| in_op | input | 2 | 0 low word, 1 high signed, 2 high signed×unsigned, 3 high unsigned |
| in_rs1 | input | 5 | First source register number |
| in_rs2 | input | 5 | Second source register number |
| in_rd | input | 5 | Destination register number |
| in_a | input | 32 | Value of the first source |
| in_b | input | 32 | Value of the second source |
| out_valid | output | 1 | A write-back is presented |
| out_rd | output | 5 | Destination of the write-back |
| out_data | output | 32 | Result word |

## Verification
The operand values used are 0x80000000 squared, 0xFFFFFFFF squared, all-ones times one, and a mixed pattern. These expose any datapath that extends an operand with the wrong bit: in that case the high word differs by one operand value from the correct result. Pairing is driven both when it must happen and when it must not. A unit that ignored the source order or the destination overlap would return the low word one cycle after the high word instead of after a full latency. A unit that missed a legal pairing would return it late. Flushes land both mid-computation and in the high-word write-back cycle. Either kind of leak shows up as a stray write-back in the event log.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [1:0] {
    OP_MUL    = 2'd0,
    OP_MULH   = 2'd1,
    OP_MULHSU = 2'd2,
    OP_MULHU  = 2'd3
  } mf_op_e;

  // Low-word opcode counts as signed: its low word does not depend on signedness.
  function automatic logic src1_signed(mf_op_e op);
    return (op == OP_MUL) || (op == OP_MULH) || (op == OP_MULHSU);
  endfunction

  function automatic logic src2_signed(mf_op_e op);
    return (op == OP_MUL) || (op == OP_MULH);
  endfunction

  function automatic logic wants_high(mf_op_e op);
    return op != OP_MUL;
  endfunction

endpackage

// File: rtl/mf_mul_core.sv
module mf_mul_core
  import mf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           calc,
  input  mf_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int EW = W + 1;
  localparam int PW = 2 * W;
  localparam int FW = 2 * EW;

  logic [W-1:0] a_q, b_q;
  logic         sa_q, sb_q;

  // One signed datapath: each operand gains one bit, a copy of its sign or a zero.
  function automatic logic [PW-1:0] wide_product(logic sx, logic sy,
                                                 logic [W-1:0] x, logic [W-1:0] y);
    logic [EW-1:0] xe, ye;
    logic [FW-1:0] p;
    xe = {sx & x[W-1], x};
    ye = {sy & y[W-1], y};
    p  = $signed({{EW{xe[EW-1]}}, xe}) * $signed({{EW{ye[EW-1]}}, ye});
    return p[PW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      sa_q <= 1'b0;
      sb_q <= 1'b0;
      prod <= '0;
    end else begin
      if (load) begin
        a_q  <= a;
        b_q  <= b;
        sa_q <= src1_signed(op);
        sb_q <= src2_signed(op);
      end
      if (calc) prod <= wide_product(sa_q, sb_q, a_q, b_q);
    end
  end

endmodule

// File: rtl/mf_fuse_detect.sv
module mf_fuse_detect
  import mf_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          window,
  input  mf_op_e        in_op,
  input  logic [RW-1:0] in_rs1,
  input  logic [RW-1:0] in_rs2,
  input  logic [RW-1:0] cur_rs1,
  input  logic [RW-1:0] cur_rs2,
  input  logic [RW-1:0] cur_rd,
  output logic          fuse_ok
);
  logic same_srcs;   // low-word op reading the same registers, same order
  logic srcs_live;   // the high-word destination leaves both sources intact

  always_comb begin
    same_srcs = (in_op == OP_MUL) && (in_rs1 == cur_rs1) && (in_rs2 == cur_rs2);
    srcs_live = (cur_rd != cur_rs1) && (cur_rd != cur_rs2);
    fuse_ok   = window && same_srcs && srcs_live;
  end

endmodule

// File: rtl/mf_ctrl.sv
module mf_ctrl
  import mf_pkg::*;
#(
  parameter int LAT = 3,
  parameter int RW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  mf_op_e        in_op,
  input  logic [RW-1:0] in_rs1,
  input  logic [RW-1:0] in_rs2,
  input  logic [RW-1:0] in_rd,
  input  logic          fuse_ok,
  output logic          in_ready,
  output logic          take_new,
  output logic          calc,
  output logic          window,
  output logic          out_valid,
  output logic          sel_lo,
  output logic          wb_second,
  output logic [RW-1:0] out_rd,
  output logic [RW-1:0] cur_rs1,
  output logic [RW-1:0] cur_rs2,
  output logic [RW-1:0] cur_rd
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WB1, S_WB2} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  mf_op_e        cur_op;
  logic [RW-1:0] lo_rd;
  logic          fused_pend;
  logic          win_closed;
  logic          take_fused;
  logic          idle;

  always_comb begin
    idle       = (st == S_IDLE);
    window     = (st == S_RUN) && wants_high(cur_op) && !fused_pend && !win_closed;
    in_ready   = !flush && (idle || fuse_ok);
    take_new   = in_valid && in_ready && idle;
    take_fused = in_valid && in_ready && !idle;
    calc       = (st == S_RUN) && (cnt == '0);
    wb_second  = (st == S_WB2);
    out_valid  = ((st == S_WB1) || (st == S_WB2)) && !flush;
    sel_lo     = wb_second || (cur_op == OP_MUL);
    out_rd     = wb_second ? lo_rd : cur_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      cur_op     <= OP_MUL;
      cur_rs1    <= '0;
      cur_rs2    <= '0;
      cur_rd     <= '0;
      lo_rd      <= '0;
      fused_pend <= 1'b0;
      win_closed <= 1'b0;
    end else if (flush) begin
      st         <= S_IDLE;
      cnt        <= '0;
      fused_pend <= 1'b0;
      win_closed <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (take_new) begin
          st         <= S_RUN;
          cnt        <= '0;
          cur_op     <= in_op;
          cur_rs1    <= in_rs1;
          cur_rs2    <= in_rs2;
          cur_rd     <= in_rd;
          fused_pend <= 1'b0;
          win_closed <= 1'b0;
        end
        S_RUN: begin
          // The first operation offered after a high-word op decides pairing.
          if (take_fused) begin
            fused_pend <= 1'b1;
            lo_rd      <= in_rd;
          end else if (window && in_valid) begin
            win_closed <= 1'b1;
          end
          if (cnt == CW'(LAT - 1)) st <= S_WB1;
          else                     cnt <= cnt + 1'b1;
        end
        S_WB1: st <= fused_pend ? S_WB2 : S_IDLE;
        S_WB2: begin
          st         <= S_IDLE;
          fused_pend <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: a write-back cycle never accepts new work
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10: after a flush no write-back follows
  p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  // R6: a paired low word leaves right behind its high word
  p_pair_adjacent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB1 && fused_pend && !flush) |=> (out_valid || flush));

  // R8: pairing only when the high destination spares both sources
  p_fuse_safe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_fused |-> (cur_rd != in_rs1 && cur_rd != in_rs2));

  // R9: pairing only behind a high-word operation
  p_fuse_after_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_fused |-> (cur_op != OP_MUL && in_op == OP_MUL));

endmodule

// File: rtl/mulfuse_unit.sv
module mulfuse_unit
  import mf_pkg::*;
#(
  parameter int XW  = 32,
  parameter int RW  = 5,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_rs1,
  input  logic [RW-1:0] in_rs2,
  input  logic [RW-1:0] in_rd,
  input  logic [XW-1:0] in_a,
  input  logic [XW-1:0] in_b,
  output logic          out_valid,
  output logic [RW-1:0] out_rd,
  output logic [XW-1:0] out_data
);
  localparam int PW = 2 * XW;

  mf_op_e        op_e;
  logic          fuse_ok;
  logic          take_new;
  logic          calc;
  logic          window;
  logic          sel_lo;
  logic          wb_second;
  logic [RW-1:0] cur_rs1, cur_rs2, cur_rd;
  logic [PW-1:0] prod;

  assign op_e = mf_op_e'(in_op);

  mf_ctrl #(.LAT(LAT), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_op(op_e), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
    .fuse_ok(fuse_ok), .in_ready(in_ready), .take_new(take_new), .calc(calc),
    .window(window), .out_valid(out_valid), .sel_lo(sel_lo),
    .wb_second(wb_second), .out_rd(out_rd),
    .cur_rs1(cur_rs1), .cur_rs2(cur_rs2), .cur_rd(cur_rd)
  );

  mf_fuse_detect #(.RW(RW)) u_detect (
    .window(window), .in_op(op_e), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .cur_rs1(cur_rs1), .cur_rs2(cur_rs2), .cur_rd(cur_rd), .fuse_ok(fuse_ok)
  );

  mf_mul_core #(.W(XW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(take_new), .calc(calc),
    .op(op_e), .a(in_a), .b(in_b), .prod(prod)
  );

  assign out_data = sel_lo ? prod[XW-1:0] : prod[PW-1:XW];

  // R6: the paired low word comes from the product already formed
  p_same_product_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_second |-> $stable(prod));

endmodule

// File: tb/sim_mulfuse_unit.sv
module sim_mulfuse_unit;
  localparam int PERIOD = 10;
  localparam int LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd1;
  logic [4:0]  in_rs1 = '0, in_rs2 = '0, in_rd = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [4:0]  out_rd;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_ev = 0;
  int          ev_cyc [0:63];
  logic [4:0]  ev_rd  [0:63];
  logic [31:0] ev_dat [0:63];

  mulfuse_unit #(.XW(32), .RW(5), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_op(in_op), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_rd(in_rd), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_rd(out_rd), .out_data(out_data)
  );

  always #(PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #2;
    if (out_valid && n_ev < 64) begin
      ev_cyc[n_ev] = cyc;
      ev_rd[n_ev]  = out_rd;
      ev_dat[n_ev] = out_data;
      n_ev = n_ev + 1;
    end
  end

  // Unsigned product, then a subtraction for each operand read as negative.
  function automatic logic [31:0] ref_word(input logic [1:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [63:0] p;
    logic [31:0] hi;
    p  = {32'b0, a} * {32'b0, b};
    hi = p[63:32];
    if ((op == 2'd1 || op == 2'd2) && a[31]) hi = hi - b;
    if (op == 2'd1 && b[31]) hi = hi - a;
    return (op == 2'd0) ? p[31:0] : hi;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] r1, input logic [4:0] r2,
                       input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b,
                       output int acc);
    in_valid = 1'b1; in_op = op; in_rs1 = r1; in_rs2 = r2; in_rd = rd;
    in_a = a; in_b = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    acc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    in_op = 2'd1;
  endtask

  task automatic settle();
    repeat (2 * LAT + 8) @(negedge clk);
  endtask

  task automatic expect_ev(input int idx, input int c_exp, input logic [4:0] rd_exp,
                           input logic [31:0] d_exp, input string tag);
    if (idx >= n_ev) begin
      chk(1'b0, {tag, " missing write-back"}, 32'(n_ev), 32'(idx + 1));
    end else begin
      chk(ev_dat[idx] == d_exp, {tag, " data"}, ev_dat[idx], d_exp);
      chk(ev_rd[idx] == rd_exp, {tag, " rd"}, 32'(ev_rd[idx]), 32'(rd_exp));
      chk(ev_cyc[idx] == c_exp, {tag, " cycle"}, 32'(ev_cyc[idx]), 32'(c_exp));
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'd0);
  endtask

  task automatic t_single(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    int acc, base;
    string tag;
    tag = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : (op == 2'd2) ? "R3" : "R4";
    base = n_ev;
    issue(op, 5'd6, 5'd7, 5'd9, a, b, acc);
    #1;
    chk(in_ready == 1'b0, "R5 ready low while busy", 32'(in_ready), 32'd0);
    settle();
    expect_ev(base, acc + LAT, 5'd9, ref_word(op, a, b), {tag, "/R5 single"});
    chk(n_ev == base + 1, "R5 one write-back", 32'(n_ev - base), 32'd1);
  endtask

  task automatic t_pair(input logic [1:0] hop, input logic [31:0] a, input logic [31:0] b);
    int ah, al, base;
    base = n_ev;
    issue(hop, 5'd3, 5'd4, 5'd10, a, b, ah);
    issue(2'd0, 5'd3, 5'd4, 5'd11, a, b, al);
    chk(al == ah + 1, "R6 low accepted at once", 32'(al), 32'(ah + 1));
    settle();
    expect_ev(base, ah + LAT, 5'd10, ref_word(hop, a, b), "R6 pair high");
    expect_ev(base + 1, ah + LAT + 1, 5'd11, ref_word(2'd0, a, b), "R6 pair low");
    chk(n_ev == base + 2, "R6 two write-backs", 32'(n_ev - base), 32'd2);
  endtask

  task automatic t_nofuse(input logic [1:0] op1, input logic [4:0] r1, input logic [4:0] r2,
                          input logic [4:0] rd1, input logic [1:0] op2, input logic [4:0] s1,
                          input logic [4:0] s2, input logic [31:0] a, input logic [31:0] b,
                          input string tag);
    int a1, a2, base;
    logic [31:0] a2v, b2v;
    base = n_ev;
    a2v = (s1 == r1) ? a : b;
    b2v = (s1 == r1) ? b : a;
    issue(op1, r1, r2, rd1, a, b, a1);
    issue(op2, s1, s2, 5'd12, a2v, b2v, a2);
    chk(a2 > a1 + LAT, {tag, " second op waited"}, 32'(a2), 32'(a1 + LAT + 1));
    settle();
    expect_ev(base, a1 + LAT, rd1, ref_word(op1, a, b), {tag, " first"});
    expect_ev(base + 1, a2 + LAT, 5'd12, ref_word(op2, a2v, b2v), {tag, " second"});
  endtask

  task automatic t_flush_run();
    int ah, al, base;
    base = n_ev;
    issue(2'd1, 5'd3, 5'd4, 5'd10, 32'hDEAD_BEEF, 32'h1357_9BDF, ah);
    issue(2'd0, 5'd3, 5'd4, 5'd11, 32'hDEAD_BEEF, 32'h1357_9BDF, al);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R10 ready after flush", 32'(in_ready), 32'd1);
    settle();
    chk(n_ev == base, "R10 mid-run flush no write-back", 32'(n_ev - base), 32'd0);
  endtask

  task automatic t_flush_wb();
    int ah, al, base;
    base = n_ev;
    issue(2'd3, 5'd5, 5'd8, 5'd13, 32'hFFFF_FFFF, 32'h0000_0002, ah);
    issue(2'd0, 5'd5, 5'd8, 5'd14, 32'hFFFF_FFFF, 32'h0000_0002, al);
    while (cyc < ah + LAT) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    settle();
    chk(n_ev == base, "R10 write-back flush drops pair", 32'(n_ev - base), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] va [0:3];
    logic [31:0] vb [0:3];
    va[0] = 32'h8000_0000; vb[0] = 32'h8000_0000;
    va[1] = 32'hFFFF_FFFF; vb[1] = 32'hFFFF_FFFF;
    va[2] = 32'hFFFF_FFFF; vb[2] = 32'h0000_0001;
    va[3] = 32'h1234_5678; vb[3] = 32'h9ABC_DEF0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int op = 0; op < 4; op++)
      for (int v = 0; v < 4; v++) t_single(2'(op), va[v], vb[v]);
    t_pair(2'd1, 32'h8000_0000, 32'h8000_0000);
    t_pair(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_pair(2'd3, 32'h1234_5678, 32'h9ABC_DEF0);
    t_nofuse(2'd1, 5'd3, 5'd4, 5'd10, 2'd0, 5'd4, 5'd3, 32'h8765_4321, 32'h0F0F_F0F0, "R7 swapped");
    t_nofuse(2'd1, 5'd3, 5'd4, 5'd3, 2'd0, 5'd3, 5'd4, 32'hFFFF_FFFF, 32'h0000_0001, "R8 rd is rs1");
    t_nofuse(2'd2, 5'd3, 5'd4, 5'd4, 2'd0, 5'd3, 5'd4, 32'h8000_0000, 32'hFFFF_FFFF, "R8 rd is rs2");
    t_nofuse(2'd0, 5'd3, 5'd4, 5'd10, 2'd0, 5'd3, 5'd4, 32'h0000_FFFF, 32'hFFFF_0000, "R9 low then low");
    t_nofuse(2'd1, 5'd3, 5'd4, 5'd10, 2'd3, 5'd3, 5'd4, 32'h8000_0001, 32'h8000_0001, "R9 high then high");
    t_flush_run();
    t_single(2'd1, 32'hFFFF_FFFF, 32'h0000_0001);
    t_flush_wb();
    t_pair(2'd1, 32'hFFFF_FFFF, 32'h0000_0001);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule